// File: doc/BRIEF.md
# Countdown-Period Step Pulse Generator

This block drives a single output pin with a train of steps timed by a countdown timer. Once enabled, the timer repeats a base period of `period_val + 1` clock cycles. At the end of each period, called a rollover, the block may issue one step. In toggle mode a step inverts the pin. In pulse mode a step drives the pin high for exactly one clock. A host writes the period, writes a step count and controls the enable line. The `done` flag tells the host when the count has run out.

A written count is not used at once. It waits in a holding register and becomes the live count at the next rollover, whether its value is zero or not. The period that ends at the first rollover after enable therefore never carries a step. The earliest step appears at the start of the second period.

A three-state machine sequences the block:
- `ST_OFF`: enable is low and the timer is parked.
- `ST_LEAD`: the first, silent period.
- `ST_RUN`: steady stepping.

The transitions are:
- `ST_OFF -> ST_LEAD` on enable high.
- `ST_LEAD -> ST_RUN` on the first rollover.
- Any state `-> ST_OFF` whenever enable is low.

Top module: `step_pulse_gen`

## Requirements
- R1: The base period is `P + 1` clock cycles, where P is the period value held at the previous reload. A countdown timer reloads P at each rollover, so P = 0 gives a rollover on every clock.
- R2: The timer loads the period at the first rising clock edge that samples `en` high. The first rollover follows P + 1 edges later.
- R3: While `en` is low, several things hold. The timer is parked and the pending count is discarded. The live count is cleared. `pin_out` is driven low. Count writes are ignored. The reset state is `pin_out` = 0 and `done` = 0.
- R4: A count written with `count_wr` becomes live only at the next rollover that follows the write edge. A write on the rollover edge itself waits for the rollover after that. A count of 0 follows the same timing.
- R5: No step is issued before the first rollover after enable. `pin_out` stays low throughout the first period.
- R6: `period_val` may be written at any time, and the timer reloads whatever value is held at the moment of each reload. A value written before enable sets the length of the first period. A value written during a period sets the length of the period that follows.
- R7: When `mode` = 0 (toggle), each step inverts `pin_out`. Between steps the level holds.
- R8: When `mode` = 1 (pulse), each step drives `pin_out` high for one clock, and `pin_out` is low otherwise. `mode` is sampled at each step.
- R9: At each rollover with a non-zero live count, the block issues one step and decrements the count by one. With a live count of zero, no step is issued and the output stays idle.
- R10: `done` rises at any rollover that leaves the live count at zero. A count write clears `done`, and this clear wins over a set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks and clears the engine |
| mode | input | 1 | 0 = toggle steps, 1 = one-clock pulse steps |
| period_wr | input | 1 | Write strobe for the period value |
| period_val | input | PW | Countdown reload value (period = value + 1 clocks) |
| count_wr | input | 1 | Write strobe for the step count |
| count_val | input | CW | Number of steps requested |
| pin_out | output | 1 | Generated step output |
| done | output | 1 | Live count exhausted at the last rollover |

## Verification
The hardest case to reach from the ports is a count write that lands on the exact edge of a rollover. On that edge the old pending value is consumed while the new one is stored, and a `done` set competes with the write's clear. The stimulus re-enables the engine many times. Each time it places the count write at a different cycle offset within a short period, sweeping every phase of the timer, including the reload edge. A behavioural reference model, compared on every clock, then checks each outcome.

// File: rtl/step_pulse_pkg.sv
package step_pulse_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2
    } sp_state_e;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_PULSE  = 1'b1
    } sp_mode_e;

endpackage

// File: rtl/sp_timer.sv
module sp_timer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic          roll
);

    logic [PW-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (start) begin
            tmr_q <= period;
        end else if (run) begin
            if (tmr_q == '0) begin
                tmr_q <= period;
            end else begin
                tmr_q <= tmr_q - PW'(1);
            end
        end else begin
            tmr_q <= '0;
        end
    end

    assign roll = run && (tmr_q == '0);

    // R1: a rollover reloads from the period register
    p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (tmr_q == $past(period)));

    // R1: between rollovers the timer counts down by one
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - PW'(1)));

    // R2: the enable edge loads the period
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tmr_q == $past(period)));

endmodule

// File: rtl/sp_counter.sv
module sp_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [CW-1:0] wval,
    input  logic          roll,
    output logic          step,
    output logic          done
);

    logic [CW-1:0] pend_q;
    logic          pend_v_q;
    logic [CW-1:0] live_q;
    logic          done_q;
    logic [CW-1:0] eff;
    logic [CW-1:0] nxt;

    always_comb begin
        eff  = pend_v_q ? pend_q : live_q;
        step = roll && (eff != '0);
        nxt  = step ? (eff - CW'(1)) : eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            live_q   <= '0;
        end else if (clr) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            live_q   <= '0;
        end else begin
            if (roll) begin
                live_q <= nxt;
            end
            if (wr) begin
                pend_q   <= wval;
                pend_v_q <= 1'b1;
            end else if (roll) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (wr) begin
            done_q <= 1'b0;
        end else if (roll && nxt == '0) begin
            done_q <= 1'b1;
        end
    end

    assign done = done_q;

    // R4: a write is held pending, not made live
    p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> pend_v_q);

    // R4: no rollover means the live count does not change
    p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll && !clr) |=> $stable(live_q));

    // R3: disable empties pending and live counts
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!pend_v_q && live_q == '0));

    // R9: a step taken from the live count decrements it
    p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pend_v_q && !clr) |=> (live_q == $past(live_q) - CW'(1)));

    // R10: a count write always clears done
    p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !done_q);

endmodule

// File: rtl/sp_shaper.sv
module sp_shaper
    import step_pulse_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic mode,
    output logic lvl
);

    logic     lvl_q;
    sp_mode_e pmode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            pmode_q <= MODE_TOGGLE;
        end else if (clr) begin
            lvl_q <= 1'b0;
        end else if (step) begin
            pmode_q <= sp_mode_e'(mode);
            unique case (sp_mode_e'(mode))
                MODE_PULSE:  lvl_q <= 1'b1;
                MODE_TOGGLE: lvl_q <= ~lvl_q;
                default:     lvl_q <= lvl_q;
            endcase
        end else if (pmode_q == MODE_PULSE) begin
            lvl_q <= 1'b0;
        end
    end

    assign lvl = lvl_q;

    // R8: a pulse-mode step produces a high level next cycle
    p_pulse_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && mode) |=> lvl_q);

    // R8: the pulse lasts one clock when no step follows
    p_pulse_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step && pmode_q == MODE_PULSE) |=> !lvl_q);

    // R7: in toggle mode the level holds between steps
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step && pmode_q == MODE_TOGGLE) |=> $stable(lvl_q));

    // R7: a toggle-mode step inverts the level
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && !mode) |=> (lvl_q != $past(lvl_q)));

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
    import step_pulse_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode,
    input  logic          period_wr,
    input  logic [PW-1:0] period_val,
    input  logic          count_wr,
    input  logic [CW-1:0] count_val,
    output logic          pin_out,
    output logic          done
);

    sp_state_e     state_q;
    sp_state_e     state_d;
    logic [PW-1:0] period_q;
    logic          start;
    logic          run;
    logic          roll;
    logic          step;
    logic          clr;
    logic          cnt_wr;

    // period register, writable at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (period_wr) begin
            period_q <= period_val;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = en ? ST_LEAD : ST_OFF;
            ST_LEAD: state_d = !en ? ST_OFF : (roll ? ST_RUN : ST_LEAD);
            ST_RUN:  state_d = !en ? ST_OFF : ST_RUN;
            default: state_d = ST_OFF;
        endcase
    end

    // control outputs of the state machine
    always_comb begin
        start  = 1'b0;
        run    = 1'b0;
        unique case (state_q)
            ST_OFF:  start = en;
            ST_LEAD: run   = en;
            ST_RUN:  run   = en;
            default: run   = 1'b0;
        endcase
        clr    = !en;
        cnt_wr = count_wr && en;
    end

    sp_timer #(.PW(PW)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .period (period_q),
        .roll   (roll)
    );

    sp_counter #(.CW(CW)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr     (cnt_wr),
        .wval   (count_val),
        .roll   (roll),
        .step   (step),
        .done   (done)
    );

    sp_shaper i_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .mode   (mode),
        .lvl    (pin_out)
    );

    // R3: enable low forces the output low on the next cycle
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pin_out);

    // R5: no step while parked, and the leading period stays quiet
    p_off_nostep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !step);

    p_lead_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> !pin_out);

    // R2: enable edge moves the machine into the leading period
    p_enter_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && en) |=> (state_q == ST_LEAD));

endmodule

// File: tb/test_step_pulse_gen.sv
module test_step_pulse_gen;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          mode = 1'b0;
    logic          period_wr = 1'b0;
    logic [PW-1:0] period_val = '0;
    logic          count_wr = 1'b0;
    logic [CW-1:0] count_val = '0;
    logic          pin_out;
    logic          done;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur = "R3";

    step_pulse_gen #(.PW(PW), .CW(CW)) i_step_pulse_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode       (mode),
        .period_wr  (period_wr),
        .period_val (period_val),
        .count_wr   (count_wr),
        .count_val  (count_val),
        .pin_out    (pin_out),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model, updated on each rising edge
    bit m_on = 0, m_pend_v = 0, m_lvl = 0, m_pulse = 0, m_done = 0;
    int m_tmr = 0, m_per = 0, m_pend = 0, m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_tmr = 0; m_per = 0; m_pend = 0; m_pend_v = 0;
            m_live = 0; m_lvl = 0; m_pulse = 0; m_done = 0;
        end else begin
            if (!en) begin
                m_on = 0; m_tmr = 0; m_pend_v = 0; m_pend = 0; m_live = 0; m_lvl = 0;
            end else if (!m_on) begin
                m_on = 1;
                m_tmr = m_per;
                if (m_pulse) m_lvl = 0;
            end else if (m_tmr == 0) begin
                int use_cnt;
                use_cnt = m_pend_v ? m_pend : m_live;
                m_pend_v = 0;
                m_tmr = m_per;
                if (use_cnt > 0) begin
                    m_live = use_cnt - 1;
                    m_pulse = mode;
                    m_lvl = mode ? 1'b1 : ~m_lvl;
                end else begin
                    m_live = 0;
                    if (m_pulse) m_lvl = 0;
                end
                if (m_live == 0) m_done = 1;
            end else begin
                m_tmr = m_tmr - 1;
                if (m_pulse) m_lvl = 0;
            end
            if (en && count_wr) begin
                m_pend = int'(count_val);
                m_pend_v = 1;
                m_done = 0;
            end
            if (period_wr) m_per = int'(period_val);
        end
    end

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (pin_out !== m_lvl || done !== m_done) begin
                n_bad++;
                $display("FAIL %s t=%0t: pin_out=%b done=%b expected pin_out=%b done=%b",
                         cur, $time, pin_out, done, m_lvl, m_done);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_period(input int v);
        period_val = PW'(v);
        period_wr  = 1'b1;
        @(negedge clk);
        period_wr  = 1'b0;
    endtask

    task automatic put_count(input int v);
        count_val = CW'(v);
        count_wr  = 1'b1;
        @(negedge clk);
        count_wr  = 1'b0;
    endtask

    task automatic summary;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cur = "R3";
        n_chk++;
        if (pin_out !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R3 reset: pin_out=%b done=%b expected 0 0", pin_out, done);
        end
        cyc(2);

        // R1, R2, R5 and R7: toggle steps at period 3
        cur = "R1/R2/R5";
        put_period(3);
        en = 1'b1;
        cyc(2);
        cur = "R7/R9";
        put_count(4);
        cyc(30);

        // R4: zero count follows the same deferred timing
        cur = "R4/R10";
        put_count(0);
        cyc(12);
        put_count(2);
        cyc(15);

        // R8: pulse mode, then period zero
        cur = "R8";
        mode = 1'b1;
        put_count(3);
        cyc(20);
        cur = "R1/R8";
        put_period(0);
        put_count(5);
        cyc(12);

        // R3: disable discards state, writes while low are ignored
        cur = "R3";
        put_count(6);
        en = 1'b0;
        cyc(2);
        put_count(7);
        cyc(3);
        cur = "R3/R5";
        put_period(2);
        en = 1'b1;
        cyc(12);

        // R6: long first period, shortened while running
        cur = "R6";
        en = 1'b0;
        mode = 1'b0;
        put_period(12);
        cyc(1);
        en = 1'b1;
        cyc(2);
        put_period(1);
        put_count(3);
        cyc(40);

        // R4 and R10: sweep the write offset across every timer phase
        for (int off = 0; off < 7; off++) begin
            cur = "R4/R10 sweep";
            en = 1'b0;
            mode = off[0];
            put_period(4);
            en = 1'b1;
            cyc(off + 1);
            put_count(2);
            cyc(3);
            put_count(1);
            cyc(18);
        end

        // R9 and R10: single step then exhaustion
        cur = "R9/R10";
        mode = 1'b0;
        put_period(2);
        put_count(1);
        cyc(15);

        summary();
    end

endmodule